// File: doc/BRIEF.md
# Multi-Port Receive Cell-Available Poller

This block is the receive-side master poller on a shared cell bus with up to eight attached port devices. Each clock it drives one device address and, one clock later, samples the shared cell-available line. The answer is written into a per-port status vector, so the poller always holds a current view of which ports have a complete cell waiting. Polling continues while a cell is being read from the selected port. A port is only read after it has answered a poll.

At the end of each cell the downstream byte-capture logic pulses `cell_end`. The poller then spends two cycles on reselection. In the first cycle it polls the port that is still selected, and it discards the answer. In the second cycle it drives the address of the next port, chosen round-robin after the last port served, with the read enable held high. In the cycle after that the enable goes low and the chosen port starts sending. The port number of every new selection is offered to the receive store on a valid/ready tag interface, so each cell can be filed with its source port.

Back-pressure on the tag interface stops the bus. While a tag waits for acceptance, the poller drives the null address, holds the enable high and keeps the tag stable. A `cell_end` that arrives during this wait is remembered and acted on once the tag is taken. In single-port mode only address 0 is polled and every tag reads 0.

Top module: `mphy_rx_poller`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the read enable is high, no tag is valid, the status vector is all zero and the driven address is 0, the first poll target.
- R2: In multi-port mode, in every cycle of a transfer that is not stalled, one port is polled, and the addresses advance 0,1,...,7,0 with no gaps.
- R3: The cell-available level in the cycle after a port's address was driven as a poll is stored in that port's status bit. A status bit rises only from such a sample.
- R4: The first reselection cycle after a cell ends drives the address of the port that is still selected (31 when no port was selected). The answer to this poll is discarded and never sets a status bit.
- R5: Reselection takes exactly two cycles. The second cycle drives the new port's address with the enable high. In the cycle after it the tag becomes valid, and the enable goes low once the tag is not being held back.
- R6: The next port is the first port with its status bit set, searching upward from the last port served and wrapping from 7 to 0. After reset the search starts at port 0.
- R7: The selected port's status bit reads 0 in the cycle after its selection.
- R8: When `single_mode` is 1, only address 0 (or the null address 31) is ever driven, only port 0 can be selected, and every tag carries port 0.
- R9: A tag that is valid while `tag_ready` is low stays valid with the same port. During that wait the address is 31 (null) and the enable is high, and a `cell_end` seen then is held until the wait ends.
- R10: If no status bit is set in the second reselection cycle, that cycle drives 31. No tag is produced, the enable stays high and the poller goes back to polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| single_mode | input | 1 | 1 selects single-port operation on address 0 |
| phy_clav | input | 1 | Shared cell-available answer from the polled port |
| phy_addr | output | ADDR_W | Port address driven on the bus; 31 is null |
| phy_enb_n | output | 1 | Read enable to the selected port, active low |
| cell_end | input | 1 | One-cycle pulse from byte capture at the last byte of a cell |
| tag_valid | output | 1 | Source-port tag for the new cell is available |
| tag_ready | input | 1 | Receive store accepts the tag |
| tag_port | output | PORT_W | Port number the coming cell is read from |
| port_status | output | NUM_PORTS | Stored poll result per port |

## Verification
The hardest case to reach from the ports is the discarded final poll. It only matters when the selected port answers "ready" to exactly that poll and to no other. The bench's port model can be armed to answer positively only for the address seen in the cycle right after `cell_end`, that is, the first reselection cycle. The bench then confirms that no further selection or status bit follows. Round-robin wrap is checked by raising several ports while a long cell is in flight, so that all of them are polled before the choice is made.

// File: rtl/mphy_rx_poll_pkg.sv
package mphy_rx_poll_pkg;

  // Sequencer phases of the poller
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,  // no port selected, polling only
    ST_XFER  = 2'd1,  // cell streaming from the selected port, polling alongside
    ST_PICK1 = 2'd2,  // reselect cycle 1: throw-away poll of the current port
    ST_PICK2 = 2'd3   // reselect cycle 2: new address, enable still high
  } poll_state_e;

endpackage

// File: rtl/mphy_rx_scan.sv
module mphy_rx_scan #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 poll_go,
  input  logic                 single_mode,
  input  logic                 clav,
  input  logic                 clr_go,
  input  logic [PORT_W-1:0]    clr_idx,
  output logic [PORT_W-1:0]    poll_idx,
  output logic [NUM_PORTS-1:0] status
);

  localparam logic [PORT_W-1:0] LAST_IDX = PORT_W'(NUM_PORTS - 1);

  logic [PORT_W-1:0] idx_q;
  logic [PORT_W-1:0] tgt_q;
  logic              vld_q;

  assign poll_idx = single_mode ? '0 : idx_q;

  // Poll pointer and a one-deep record of which address awaits its answer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      tgt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= poll_go;
      tgt_q <= poll_idx;
      if (poll_go && !single_mode)
        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        status[g] <= 1'b0;
      else if (clr_go && clr_idx == PORT_W'(g))
        status[g] <= 1'b0;
      else if (vld_q && tgt_q == PORT_W'(g))
        status[g] <= clav;
    end

    // R3: a status bit can only rise from a positive answer on the bus
    assert_fresh_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[g]) |-> $past(clav))
      else $error("status bit rose without a cell-available answer");
  end

endmodule

// File: rtl/mphy_rx_rr.sv
module mphy_rx_rr #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0] status,
  input  logic                 single_mode,
  input  logic [PORT_W-1:0]    last,
  output logic                 found,
  output logic [PORT_W-1:0]    pick
);

  logic [NUM_PORTS-1:0] masked;

  assign masked = single_mode ? NUM_PORTS'(status[0]) : status;

  // R6: search upward from the port after the last one served, wrapping
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      int idx;
      idx = (int'(last) + k) % NUM_PORTS;
      if (!found && masked[idx]) begin
        found = 1'b1;
        pick  = PORT_W'(idx);
      end
    end
  end

endmodule

// File: rtl/mphy_rx_ctrl.sv
module mphy_rx_ctrl
  import mphy_rx_poll_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_mode,
  input  logic              cell_end,
  input  logic              found,
  input  logic [PORT_W-1:0] pick,
  input  logic              tag_ready,
  output poll_state_e       state,
  output logic              stall,
  output logic              have_cur,
  output logic [PORT_W-1:0] cur_port,
  output logic [PORT_W-1:0] last_port,
  output logic              clr_go,
  output logic              tag_valid,
  output logic [PORT_W-1:0] tag_port
);

  logic done_pend;

  assign stall  = tag_valid && !tag_ready;
  assign clr_go = (state == ST_PICK2) && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SCAN;
      done_pend <= 1'b0;
      have_cur  <= 1'b0;
      cur_port  <= '0;
      last_port <= PORT_W'(NUM_PORTS - 1);
      tag_valid <= 1'b0;
      tag_port  <= '0;
    end else begin
      if (tag_valid && tag_ready)
        tag_valid <= 1'b0;
      unique case (state)
        ST_SCAN: begin
          if (found)
            state <= ST_PICK1;
        end
        ST_XFER: begin
          if (cell_end || done_pend) begin
            if (stall) begin
              done_pend <= 1'b1;          // R9: hold the cell end until the tag drains
            end else begin
              done_pend <= 1'b0;
              state     <= ST_PICK1;
            end
          end
        end
        ST_PICK1: state <= ST_PICK2;
        ST_PICK2: begin
          if (found) begin
            state     <= ST_XFER;
            tag_valid <= 1'b1;
            tag_port  <= single_mode ? '0 : pick;
            cur_port  <= pick;
            last_port <= pick;
            have_cur  <= 1'b1;
          end else begin
            state    <= ST_SCAN;
            have_cur <= 1'b0;
          end
        end
        default: state <= ST_SCAN;
      endcase
    end
  end

  assert_tag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_ready) |=> (tag_valid && $stable(tag_port)))
    else $error("tag changed while back-pressured");

  assert_single_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && single_mode) |-> (tag_port == '0))
    else $error("single-port tag is not zero");

  assert_two_cycle_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PICK1) |=> (state == ST_PICK2))
    else $error("reselection did not take two cycles");

  assert_end_starts_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && cell_end && !stall) |=> (state == ST_PICK1))
    else $error("cell end did not start reselection");

  assert_empty_pick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PICK2 && !found) |=> (!tag_valid && state == ST_SCAN))
    else $error("empty reselection produced a tag");

endmodule

// File: rtl/mphy_rx_poller.sv
module mphy_rx_poller
  import mphy_rx_poll_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int ADDR_W    = 5,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 single_mode,
  input  logic                 phy_clav,
  output logic [ADDR_W-1:0]    phy_addr,
  output logic                 phy_enb_n,
  input  logic                 cell_end,
  output logic                 tag_valid,
  input  logic                 tag_ready,
  output logic [PORT_W-1:0]    tag_port,
  output logic [NUM_PORTS-1:0] port_status
);

  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  poll_state_e       state;
  logic              stall;
  logic              have_cur;
  logic [PORT_W-1:0] cur_port;
  logic [PORT_W-1:0] last_port;
  logic              clr_go;
  logic              found;
  logic [PORT_W-1:0] pick;
  logic [PORT_W-1:0] poll_idx;
  logic              poll_go;

  assign poll_go   = (state == ST_SCAN || state == ST_XFER) && !stall;
  assign phy_enb_n = !(state == ST_XFER && !stall);

  always_comb begin
    unique case (state)
      ST_SCAN, ST_XFER: phy_addr = poll_go  ? ADDR_W'(poll_idx) : NULL_ADDR;
      ST_PICK1:         phy_addr = have_cur ? ADDR_W'(cur_port) : NULL_ADDR;
      ST_PICK2:         phy_addr = found    ? ADDR_W'(pick)     : NULL_ADDR;
      default:          phy_addr = NULL_ADDR;
    endcase
  end

  mphy_rx_scan #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_go     (poll_go),
    .single_mode (single_mode),
    .clav        (phy_clav),
    .clr_go      (clr_go),
    .clr_idx     (pick),
    .poll_idx    (poll_idx),
    .status      (port_status)
  );

  mphy_rx_rr #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_rr (
    .status      (port_status),
    .single_mode (single_mode),
    .last        (last_port),
    .found       (found),
    .pick        (pick)
  );

  mphy_rx_ctrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_mode (single_mode),
    .cell_end    (cell_end),
    .found       (found),
    .pick        (pick),
    .tag_ready   (tag_ready),
    .state       (state),
    .stall       (stall),
    .have_cur    (have_cur),
    .cur_port    (cur_port),
    .last_port   (last_port),
    .clr_go      (clr_go),
    .tag_valid   (tag_valid),
    .tag_port    (tag_port)
  );

  assert_null_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_ready) |-> (phy_addr == NULL_ADDR && phy_enb_n))
    else $error("bus not parked while tag is back-pressured");

  assert_enable_after_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_enb_n) |-> tag_valid)
    else $error("enable dropped without a fresh selection tag");

  assert_clear_on_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> !port_status[$past(pick)])
    else $error("selected port status not cleared");

endmodule

// File: tb/mphy_rx_poller_bench.sv
module mphy_rx_poller_bench;

  localparam int CELL_LEN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       single_mode = 1'b0;
  logic       phy_clav = 1'b0;
  logic       cell_end = 1'b0;
  logic       tag_ready = 1'b1;
  logic [4:0] phy_addr;
  logic       phy_enb_n;
  logic       tag_valid;
  logic [2:0] tag_port;
  logic [7:0] port_status;

  always #2 clk = ~clk;   // 250 MHz

  mphy_rx_poller u_mphy_rx_poller (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .phy_clav(phy_clav),
    .phy_addr(phy_addr), .phy_enb_n(phy_enb_n), .cell_end(cell_end),
    .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_port(tag_port),
    .port_status(port_status)
  );

  int   checks = 0;
  int   errors = 0;
  int   served = 0;
  int   exp_q[$];
  logic [7:0] ready = '0;
  bit   lie_arm = 1'b0;
  int   lie_port = 0;
  // port model and history, updated at falling edges
  int   cap_addr = 31;
  bit   cap_lie = 1'b0;
  int   cell_cnt = 0;
  int   a1 = 31, a2 = 31;
  bit   e1 = 1'b1, e2 = 1'b1, e3 = 1'b1;
  bit   tv_prev = 1'b0;
  int   bench_cur = 31;
  bit   clr_pend = 1'b0;
  int   clr_port = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor, port model and cell-length generator
  always @(negedge clk) begin
    if (rst_n) begin
      if (clr_pend) begin
        check(port_status[clr_port] == 1'b0, "R7 status cleared on select",
              int'(port_status[clr_port]), 0);
        clr_pend = 1'b0;
      end
      if (tag_valid && !tv_prev) begin
        check(a1 == int'(tag_port), "R5 second pick cycle address", a1, int'(tag_port));
        check(e1 == 1'b1, "R5 enable high in second pick cycle", int'(e1), 1);
        check(a2 == ((e3 == 1'b0) ? bench_cur : 31), "R4 first pick cycle polls current port",
              a2, (e3 == 1'b0) ? bench_cur : 31);
      end
      if (tag_valid && tag_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected selection", int'(tag_port), -1);
        end else begin
          int exp_p;
          exp_p = exp_q.pop_front();
          check(int'(tag_port) == exp_p, "R6 round-robin order", int'(tag_port), exp_p);
        end
        if (single_mode) check(tag_port == 3'd0, "R8 single-port tag", int'(tag_port), 0);
        check(phy_enb_n == 1'b0, "R5 enable low after selection", int'(phy_enb_n), 0);
        ready[tag_port] = 1'b0;
        bench_cur = int'(tag_port);
        clr_pend  = 1'b1;
        clr_port  = int'(tag_port);
        served++;
      end
      if (!phy_enb_n && !e1 && !single_mode)
        check(int'(phy_addr) == ((a1 + 1) % 8), "R2 poll sequence", int'(phy_addr), (a1 + 1) % 8);
      if (single_mode)
        check(phy_addr == 5'd0 || phy_addr == 5'd31, "R8 only address 0 polled", int'(phy_addr), 0);
      // port model: answer the address driven one cycle earlier
      phy_clav = cap_lie || (cap_addr < 8 && ready[cap_addr[2:0]]);
      cap_lie  = lie_arm && cell_end && (int'(phy_addr) == lie_port);
      cap_addr = int'(phy_addr);
      // cell length generator
      if (cell_end) begin
        cell_end = 1'b0;
      end else if (!phy_enb_n) begin
        cell_cnt++;
        if (cell_cnt == CELL_LEN) begin
          cell_end = 1'b1;
          cell_cnt = 0;
        end
      end
      e3 = e2; e2 = e1; e1 = phy_enb_n;
      a2 = a1; a1 = int'(phy_addr);
      tv_prev = tag_valid;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_served(input int n);
    while (served < n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick(5);
    // R1: reset state
    check(phy_addr == 5'd0, "R1 reset address", int'(phy_addr), 0);
    check(phy_enb_n == 1'b1, "R1 reset enable", int'(phy_enb_n), 1);
    check(tag_valid == 1'b0, "R1 reset tag", int'(tag_valid), 0);
    check(port_status == 8'h00, "R1 reset status", int'(port_status), 0);
    rst_n = 1'b1;
    tick(3);

    // R6/R3: one port, then three raised during its cell
    ready[3] = 1'b1; exp_q.push_back(3);
    wait_served(1);
    ready[2] = 1'b1; ready[5] = 1'b1; ready[6] = 1'b1;
    exp_q.push_back(5); exp_q.push_back(6); exp_q.push_back(2);
    tick(11);
    check(port_status[2] && port_status[5] && port_status[6], "R3 poll answers stored",
          int'(port_status), 8'h64);
    wait_served(4);
    tick(40);

    // R6: wrap from 7 to 0
    ready[4] = 1'b1; exp_q.push_back(4);
    wait_served(5);
    ready[0] = 1'b1; ready[7] = 1'b1;
    exp_q.push_back(7); exp_q.push_back(0);
    wait_served(7);
    tick(40);

    // R9: tag back-pressure parks the bus
    tag_ready = 1'b0;
    ready[1] = 1'b1; exp_q.push_back(1);
    while (!tag_valid) tick(1);
    for (int i = 0; i < 6; i++) begin
      check(phy_addr == 5'd31, "R9 null address while stalled", int'(phy_addr), 31);
      check(phy_enb_n == 1'b1, "R9 enable high while stalled", int'(phy_enb_n), 1);
      check(tag_valid && tag_port == 3'd1, "R9 tag held", int'(tag_port), 1);
      tick(1);
    end
    tag_ready = 1'b1;
    wait_served(8);
    tick(40);

    // R4/R10: selected port answers only the throw-away poll
    lie_port = 4; lie_arm = 1'b1;
    ready[4] = 1'b1; exp_q.push_back(4);
    wait_served(9);
    tick(40);
    for (int i = 0; i < 20; i++) begin
      check(port_status == 8'h00, "R4 discarded answer not stored", int'(port_status), 0);
      check(tag_valid == 1'b0 && phy_enb_n == 1'b1, "R10 no selection when none ready",
            int'(tag_valid), 0);
      tick(1);
    end
    lie_arm = 1'b0;

    // R8: single-port mode
    single_mode = 1'b1;
    ready[3] = 1'b1; ready[0] = 1'b1; exp_q.push_back(0);
    wait_served(10);
    tick(40);
    check(port_status[3] == 1'b0, "R8 other ports never polled", int'(port_status[3]), 0);
    check(tag_valid == 1'b0, "R8 no further selection", int'(tag_valid), 0);
    ready[3] = 1'b0;

    check(exp_q.size() == 0, "R6 all expected selections seen", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", served, 10);
    finish_run();
  end

endmodule